// File: doc/BRIEF.md
# Self-locking write-mask control register

The block holds a 64-bit control register and a 64-bit mask register that guards it. Each implemented mask bit, when set, freezes the matching bit of the control register. A write to the control register then changes only the unmasked bits. The control register can be reached under two names, a primary one and an alias. Both paths go through the same mask, so the alias gives no way around the protection.

The mask register protects itself from the least privileged writer that may touch it. A write to the mask from privilege level 1 is refused while any mask bit is set, and the refusal is reported as an undefined access. Levels 2 and 3 can always rewrite the mask. Level 0 may not write either register, and every level-0 write is reported as undefined.

Only seven mask positions can ever hold a one: 31, 30, 29, 28, 24, 20 and 16. Six of these positions depend on optional features, chosen by parameters. Position 20 is always present. The top reports the set of implemented positions on a status output. Trap routing is not part of this block; it only signals that an access was refused.

Top module: `fieldlock_csr`

## Requirements
- R1: While `rst` is high and at the first edge after it, `ctrl_q`, `mask_q` and `wr_undef` are all zero.
- R2: A write accepted to the control target (`wr_target`=0) loads `wr_data` into every control bit whose mask bit is 0. The new value is visible one cycle after the write edge.
- R3: On any accepted control write, every control bit whose mask bit is 1 keeps its previous value.
- R4: A write to the alias target (`wr_target`=1) updates the control register by exactly the same masked rule as the primary target.
- R5: `mask_q` always reads zero at bits 63:32, 27:25, 23:21, 19:17 and 15:0. Written data at those positions is dropped.
- R6: An optional mask position whose feature parameter is 0 reads as zero and cannot be set.
  - Position 31 needs the nested-virtualisation feature.
  - Position 30 needs both the activity-monitor and the nested-virtualisation features.
  - Position 29 needs the permission-overlay feature.
  - Position 28 needs the trace-register feature.
  - Position 24 needs the matrix-extension feature.
  - Position 16 needs the vector-extension feature.
- R7: A mask write (`wr_target`=2) at `wr_priv`=1 while `mask_q` is nonzero has two effects:
  - `mask_q` does not change.
  - `wr_undef` is high for the next cycle.
- R8: A mask write at `wr_priv`=1 while `mask_q` is zero stores `wr_data` masked to the implemented positions. `wr_undef` stays low.
- R9: A mask write at `wr_priv`=2 or 3 always stores `wr_data` masked to the implemented positions, whatever `mask_q` holds.
- R10: A write at `wr_priv`=0 to targets 0, 1 or 2 has two effects:
  - Neither register changes.
  - `wr_undef` is high for the next cycle.
- R11: `impl_bits` has a one exactly at each implemented mask position. With default parameters it reads 64'h0000_0000_F111_0000.
- R12: When `wr_en` is 0, or `wr_target`=3, neither register changes and `wr_undef` is low the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request strobe |
| wr_target | input | 2 | 0 control, 1 control alias, 2 mask, 3 none |
| wr_priv | input | 2 | Privilege level of the requester, 0 to 3 |
| wr_data | input | 64 | Write data |
| ctrl_q | output | 64 | Control register read-back |
| mask_q | output | 64 | Mask register read-back |
| wr_undef | output | 1 | High for one cycle after a refused write |
| impl_bits | output | 64 | Implemented mask positions |

## Verification
The bench targets the mask lock at level 1. It refuses writes only while the mask is nonzero, and it reopens once level 2 or 3 clears the mask. A design that tested the incoming data instead of the stored mask would let the lock be lifted from level 1. A design that ignored privilege would freeze the mask for every level.

The bench also writes through the alias with masked bits set. A design that filtered only the primary path would change frozen bits there.

A second instance with all optional features disabled checks the remaining corner. Writing all ones to its mask must leave only bit 20 set. A design that kept absent positions would show extra ones.

// File: rtl/fieldlock_pkg.sv
package fieldlock_pkg;

    localparam int XLEN       = 64;
    localparam int NUM_FIELDS = 7;

    typedef enum logic [1:0] {
        TGT_CTRL  = 2'd0,
        TGT_ALIAS = 2'd1,
        TGT_MASK  = 2'd2,
        TGT_NONE  = 2'd3
    } target_e;

    typedef enum logic [1:0] {
        PL_USER   = 2'd0,
        PL_KERNEL = 2'd1,
        PL_HYP    = 2'd2,
        PL_MON    = 2'd3
    } priv_e;

    typedef struct packed {
        logic ctrl_we;
        logic mask_we;
        logic undef;
    } wr_dec_t;

    // Bit position in the mask register of each lockable field.
    function automatic int field_pos(input int idx);
        case (idx)
            0:       return 16;
            1:       return 20;
            2:       return 24;
            3:       return 28;
            4:       return 29;
            5:       return 30;
            default: return 31;
        endcase
    endfunction

    // Expand a per-field presence vector into a full-width bit map.
    function automatic logic [XLEN-1:0] expand_fields(input logic [NUM_FIELDS-1:0] present);
        logic [XLEN-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            v[field_pos(i)] = present[i];
        end
        return v;
    endfunction

    // Protected bits keep old contents, the rest take new data.
    function automatic logic [XLEN-1:0] merge_under_mask(
        input logic [XLEN-1:0] old_v,
        input logic [XLEN-1:0] new_v,
        input logic [XLEN-1:0] lock
    );
        return (old_v & lock) | (new_v & ~lock);
    endfunction

endpackage

// File: rtl/fieldlock_decode.sv
module fieldlock_decode
    import fieldlock_pkg::*;
(
    input  logic       wr_en,
    input  logic [1:0] wr_target,
    input  logic [1:0] wr_priv,
    input  logic       mask_nonzero,
    output wr_dec_t    dec
);
    target_e tgt;
    priv_e   lvl;
    logic    is_reg_target;

    assign tgt = target_e'(wr_target);
    assign lvl = priv_e'(wr_priv);
    assign is_reg_target = (tgt == TGT_CTRL) || (tgt == TGT_ALIAS) || (tgt == TGT_MASK);

    always_comb begin
        dec = '0;
        if (wr_en && is_reg_target) begin
            if (lvl == PL_USER) begin
                dec.undef = 1'b1;
            end else if (tgt == TGT_MASK) begin
                if (lvl == PL_KERNEL && mask_nonzero) begin
                    dec.undef = 1'b1;
                end else begin
                    dec.mask_we = 1'b1;
                end
            end else begin
                dec.ctrl_we = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fieldlock_maskreg.sv
module fieldlock_maskreg
    import fieldlock_pkg::*;
#(
    parameter logic [NUM_FIELDS-1:0] PRESENT = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [XLEN-1:0] data,
    output logic [XLEN-1:0] q
);
    logic [NUM_FIELDS-1:0] field_q;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam int POS = field_pos(i);
        if (PRESENT[i]) begin : g_on
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    bit_q <= 1'b0;
                end else if (we) begin
                    bit_q <= data[POS];
                end
            end
            assign field_q[i] = bit_q;
        end else begin : g_off
            assign field_q[i] = 1'b0;
        end
    end

    assign q = expand_fields(field_q);
endmodule

// File: rtl/fieldlock_ctrlreg.sv
module fieldlock_ctrlreg
    import fieldlock_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [XLEN-1:0] data,
    input  logic [XLEN-1:0] lock,
    output logic [XLEN-1:0] q
);
    logic [XLEN-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (we) begin
            q_r <= merge_under_mask(q_r, data, lock);
        end
    end

    assign q = q_r;
endmodule

// File: rtl/fieldlock_csr.sv
module fieldlock_csr
    import fieldlock_pkg::*;
#(
    parameter bit HAS_NESTED_VIRT   = 1'b1,
    parameter bit HAS_ACTIVITY_MON  = 1'b1,
    parameter bit HAS_PERM_OVERLAY  = 1'b1,
    parameter bit HAS_TRACE_SYSREG  = 1'b1,
    parameter bit HAS_MATRIX_EXT    = 1'b1,
    parameter bit HAS_VECTOR_EXT    = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_target,
    input  logic [1:0]  wr_priv,
    input  logic [63:0] wr_data,
    output logic [63:0] ctrl_q,
    output logic [63:0] mask_q,
    output logic        wr_undef,
    output logic [63:0] impl_bits
);
    // Field presence in field_pos() order: 16, 20, 24, 28, 29, 30, 31.
    localparam logic [NUM_FIELDS-1:0] PRESENT = {
        HAS_NESTED_VIRT,
        HAS_NESTED_VIRT & HAS_ACTIVITY_MON,
        HAS_PERM_OVERLAY,
        HAS_TRACE_SYSREG,
        HAS_MATRIX_EXT,
        1'b1,
        HAS_VECTOR_EXT
    };
    localparam logic [XLEN-1:0] IMPL = expand_fields(PRESENT);

    wr_dec_t         dec;
    logic [XLEN-1:0] mask_w;
    logic            undef_q;

    fieldlock_decode u_decode (
        .wr_en        (wr_en),
        .wr_target    (wr_target),
        .wr_priv      (wr_priv),
        .mask_nonzero (|mask_w),
        .dec          (dec)
    );

    fieldlock_maskreg #(.PRESENT(PRESENT)) u_mask (
        .clk  (clk),
        .rst  (rst),
        .we   (dec.mask_we),
        .data (wr_data),
        .q    (mask_w)
    );

    fieldlock_ctrlreg u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .we   (dec.ctrl_we),
        .data (wr_data),
        .lock (mask_w),
        .q    (ctrl_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            undef_q <= 1'b0;
        end else begin
            undef_q <= dec.undef;
        end
    end

    assign mask_q    = mask_w;
    assign wr_undef  = undef_q;
    assign impl_bits = IMPL;
endmodule

// File: rtl/fieldlock_csr_sva.sv
module fieldlock_csr_sva (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_target,
    input logic [1:0]  wr_priv,
    input logic [63:0] wr_data,
    input logic [63:0] ctrl_q,
    input logic [63:0] mask_q,
    input logic        wr_undef,
    input logic [63:0] impl_bits
);
    logic ctrl_acc;
    assign ctrl_acc = wr_en && (wr_target == 2'd0 || wr_target == 2'd1) && wr_priv != 2'd0;

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_q == 64'd0 && mask_q == 64'd0 && !wr_undef));

    p_unmasked_take_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_acc |=> ((ctrl_q & ~$past(mask_q)) == ($past(wr_data) & ~$past(mask_q))));

    // R4: the alias path is covered because ctrl_acc includes target 1.
    p_masked_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ctrl_acc |=> ((ctrl_q & $past(mask_q)) == ($past(ctrl_q) & $past(mask_q))));

    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (mask_q & ~impl_bits) == 64'd0);

    p_lock_refuse_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_target == 2'd2 && wr_priv == 2'd1 && mask_q != 64'd0)
        |=> ($stable(mask_q) && wr_undef));

    p_high_priv_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_target == 2'd2 && wr_priv[1])
        |=> (mask_q == ($past(wr_data) & impl_bits) && !wr_undef));

    p_user_refuse_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_target != 2'd3 && wr_priv == 2'd0)
        |=> ($stable(ctrl_q) && $stable(mask_q) && wr_undef));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || wr_target == 2'd3)
        |=> ($stable(ctrl_q) && $stable(mask_q) && !wr_undef));
endmodule

bind fieldlock_csr fieldlock_csr_sva u_sva (.*);

// File: tb/fieldlock_csr_tb.sv
module fieldlock_csr_tb;
    localparam logic [63:0] IMPL_FULL = 64'h0000_0000_F111_0000;
    localparam logic [63:0] IMPL_MIN  = 64'h0000_0000_0010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_target = 2'd0;
    logic [1:0]  wr_priv = 2'd0;
    logic [63:0] wr_data = 64'd0;
    logic [63:0] ctrl_q, mask_q, impl_bits;
    logic [63:0] ctrl_m, mask_m, impl_m;
    logic        wr_undef, undef_m;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] rc, rm, rc_min, rm_min;
    logic        ru, ru_min;

    always #10 clk = ~clk;

    fieldlock_csr u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_target(wr_target),
        .wr_priv(wr_priv), .wr_data(wr_data), .ctrl_q(ctrl_q),
        .mask_q(mask_q), .wr_undef(wr_undef), .impl_bits(impl_bits)
    );

    fieldlock_csr #(
        .HAS_NESTED_VIRT(1'b0), .HAS_ACTIVITY_MON(1'b0), .HAS_PERM_OVERLAY(1'b0),
        .HAS_TRACE_SYSREG(1'b0), .HAS_MATRIX_EXT(1'b0), .HAS_VECTOR_EXT(1'b0)
    ) u_dut_min (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_target(wr_target),
        .wr_priv(wr_priv), .wr_data(wr_data), .ctrl_q(ctrl_m),
        .mask_q(mask_m), .wr_undef(undef_m), .impl_bits(impl_m)
    );

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model(input logic en, input logic [1:0] tgt, input logic [1:0] pl,
                         input logic [63:0] d, input logic [63:0] impl,
                         inout logic [63:0] c, inout logic [63:0] m, inout logic u);
        u = 1'b0;
        if (en && tgt != 2'd3) begin
            if (pl == 2'd0) u = 1'b1;
            else if (tgt == 2'd2) begin
                if (pl == 2'd1 && m != 64'd0) u = 1'b1;
                else m = d & impl;
            end else begin
                for (int b = 0; b < 64; b++)
                    if (!m[b]) c[b] = d[b];
            end
        end
    endtask

    task automatic compare_all(input string tag);
        check64({tag, " ctrl"}, ctrl_q, rc);
        check64({tag, " mask"}, mask_q, rm);
        check64({tag, " undef"}, {63'd0, wr_undef}, {63'd0, ru});
        check64({tag, " min ctrl"}, ctrl_m, rc_min);
        check64({tag, " min mask"}, mask_m, rm_min);
        check64({tag, " min undef"}, {63'd0, undef_m}, {63'd0, ru_min});
    endtask

    task automatic apply(input string tag, input logic en, input logic [1:0] tgt,
                         input logic [1:0] pl, input logic [63:0] d);
        wr_en = en; wr_target = tgt; wr_priv = pl; wr_data = d;
        model(en, tgt, pl, d, IMPL_FULL, rc, rm, ru);
        model(en, tgt, pl, d, IMPL_MIN, rc_min, rm_min, ru_min);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rc = 0; rm = 0; ru = 0; rc_min = 0; rm_min = 0; ru_min = 0;
        repeat (3) @(negedge clk);
        compare_all("R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        compare_all("R1 after reset");
        check64("R11 impl map", impl_bits, IMPL_FULL);
        check64("R6 impl map minimal", impl_m, IMPL_MIN);

        apply("R2 ctrl all ones", 1, 2'd0, 2'd1, '1);
        apply("R2 ctrl pattern", 1, 2'd0, 2'd2, 64'h0123_4567_89AB_CDEF);
        apply("R8 R5 R6 mask set from level 1", 1, 2'd2, 2'd1, '1);
        apply("R3 ctrl clear under mask", 1, 2'd0, 2'd1, 64'd0);
        apply("R4 alias all ones under mask", 1, 2'd1, 2'd1, '1);
        apply("R7 mask lock refuse", 1, 2'd2, 2'd1, 64'd0);
        apply("R12 idle after refuse", 0, 2'd2, 2'd1, 64'd0);
        apply("R9 level 2 rewrite", 1, 2'd2, 2'd2, 64'h0000_0000_0001_0000);
        apply("R7 single bit still locks", 1, 2'd2, 2'd1, 64'd0);
        apply("R9 level 3 clear", 1, 2'd2, 2'd3, 64'd0);
        apply("R8 level 1 reopen", 1, 2'd2, 2'd1, 64'h0000_0000_0010_0000);
        apply("R10 user ctrl", 1, 2'd0, 2'd0, 64'd0);
        apply("R10 user mask", 1, 2'd2, 2'd0, 64'd0);
        apply("R10 user alias", 1, 2'd1, 2'd0, 64'd0);
        apply("R12 none target", 1, 2'd3, 2'd3, 64'd0);
        apply("R12 no strobe", 0, 2'd0, 2'd3, 64'd0);
        apply("R5 mask reserved dropped", 1, 2'd2, 2'd3, 64'hFFFF_FFFF_0EEE_FFFF);
        apply("R9 mask full", 1, 2'd2, 2'd3, 64'hA5A5_A5A5_F111_0000);
        apply("R4 alias pattern", 1, 2'd1, 2'd3, 64'hA5A5_A5A5_A5A5_A5A5);
        apply("R3 ctrl pattern", 1, 2'd0, 2'd2, 64'h5A5A_5A5A_5A5A_5A5A);
        apply("R12 final idle", 0, 2'd0, 2'd0, 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule